// File: doc/BRIEF.md
# Speculative Multi-Tap Decision Feedback Equaliser

This block removes post-cursor inter-symbol interference from a stream of signed, already digitised received samples, taking at most one sample per clock. It remembers the last few hard decisions, each worth +1 or -1. It multiplies each remembered decision by a programmable tap weight and subtracts the total from the new sample. The corrected value is then compared with a reference level to give the next decision.

The weight for the most recent decision is not applied in series. Instead, two corrected values are formed in parallel: one assumes the previous decision was +1 and the other assumes it was -1. Each is sliced on its own, and the real previous decision picks the result. The older taps are subtracted directly from the stored decision chain.

The block reports the decision bit and the fully corrected value that was sliced. It does nothing about pre-cursor interference or about noise in the current symbol, because it only uses past decisions. Tap weights are loaded through a simple write port. The weights are typically set once and then left alone while data streams.

Top module: `spec_dfe`

## Requirements
- R1: While `rst` is high, `in_ready`, `out_valid`, `out_bit` and `out_eq` are 0. Reset loads all tap weights with 0 and loads every stored decision with +1.
- R2: With `coef_we` high at a clock edge, `coef_val` is loaded as the weight of tap `coef_idx`+1, so index 0 is the weight for the most recent decision. The new weight applies to samples accepted at later edges. A sample accepted at the same edge as the write still uses the old weight.
- R3: Each accepted sample pushes its decision onto the front of an NTAPS-deep decision chain. An edge with no accepted sample leaves the chain unchanged.
- R4: For an accepted sample x, `out_eq` = x − Σ(k=1..NTAPS) c_k·D(j−k). D is +1 for a stored decision bit 1 and −1 for a bit 0. The result is carried at full precision, without overflow, for every input and weight value.
- R5: `out_bit` is 1 exactly when `out_eq` ≥ `slice_ref`, with both compared as signed values. A tie yields 1.
- R6: `out_valid` is high for exactly one cycle, one cycle after each accepted sample. `out_bit` and `out_eq` keep their values when no sample is accepted.
- R7: `in_ready` is high whenever `rst` is low, so a sample is accepted on every edge where `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is offered |
| in_ready | output | 1 | The block can take a sample |
| in_sample | input | SAMPLE_W | Signed received sample |
| slice_ref | input | SAMPLE_W | Signed slicing threshold |
| coef_we | input | 1 | Load one tap weight |
| coef_idx | input | clog2(NTAPS) | Tap to load, 0 = most recent decision |
| coef_val | input | COEF_W | Signed tap weight |
| out_valid | output | 1 | Decision and corrected value are new |
| out_bit | output | 1 | Decision, 1 = +1, 0 = −1 |
| out_eq | output | ACC_W | Signed corrected pre-slicer value |

## Verification
A tap-weight write and a sample acceptance can land on the same clock edge. The bench provokes this by changing a weight mid-stream in the very cycle a sample is offered. It judges the result by requiring that sample to carry the old weight, and the next sample to carry the new one. The main sweeps walk the whole input range in a scrambled order under zero, extreme-negative, extreme-positive and mixed weights, with several thresholds. This makes the decision history drift through both polarities of the tap-1 selection and hits the exact tie against the threshold.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  function automatic int acc_width(input int sw, input int cw, input int n);
    int m;
    m = (sw > cw) ? sw : cw;
    return m + $clog2(n) + 2;
  endfunction
endpackage

// File: rtl/dfe_coef_bank.sv
module dfe_coef_bank #(
  parameter int COEF_W = 8,
  parameter int NTAPS  = 4,
  localparam int IDX_W = $clog2(NTAPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic signed [COEF_W-1:0] wr_val,
  output logic signed [COEF_W-1:0] coef_o [NTAPS]
);
  logic signed [COEF_W-1:0] bank_q [NTAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAPS; i++) bank_q[i] <= '0;
    end else if (wr_en && (int'(wr_idx) < NTAPS)) begin
      bank_q[wr_idx] <= wr_val;
    end
  end

  for (genvar g = 0; g < NTAPS; g++) begin : g_out
    assign coef_o[g] = bank_q[g];
    AST_COEF_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(bank_q[g])); // R2
  end
endmodule

// File: rtl/dfe_hist.sv
module dfe_hist #(
  parameter int NTAPS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             dec,
  output logic [NTAPS-1:0] hist_o
);
  logic [NTAPS-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst)       hist_q <= '1;
    else if (push) hist_q <= {hist_q[NTAPS-2:0], dec};
  end

  assign hist_o = hist_q;

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !push |=> $stable(hist_q)); // R3
endmodule

// File: rtl/dfe_spec_slicer.sv
module dfe_spec_slicer #(
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8,
  parameter int NTAPS    = 4,
  parameter int ACC_W    = 12
) (
  input  logic signed [SAMPLE_W-1:0] x,
  input  logic signed [SAMPLE_W-1:0] thr,
  input  logic signed [COEF_W-1:0]   coef [NTAPS],
  input  logic [NTAPS-1:0]           hist,
  output logic                       dec,
  output logic signed [ACC_W-1:0]    eq
);
  logic signed [ACC_W-1:0] term [NTAPS];
  logic signed [ACC_W-1:0] fb_hi, x_w, thr_w, c1_w, cand_p, cand_m;
  logic                    dec_p, dec_m;

  // taps 2..N: direct feedback from the stored chain
  for (genvar k = 1; k < NTAPS; k++) begin : g_term
    logic signed [ACC_W-1:0] cw;
    assign cw      = ACC_W'(coef[k]);
    assign term[k] = hist[k] ? cw : -cw;
  end
  assign term[0] = '0;

  always_comb begin
    fb_hi = '0;
    for (int k = 1; k < NTAPS; k++) fb_hi = fb_hi + term[k];
  end

  assign x_w   = ACC_W'(x);
  assign thr_w = ACC_W'(thr);
  assign c1_w  = ACC_W'(coef[0]);

  // tap 1: both outcomes prepared, previous decision selects
  assign cand_p = x_w - fb_hi - c1_w;
  assign cand_m = x_w - fb_hi + c1_w;
  assign dec_p  = (cand_p >= thr_w);
  assign dec_m  = (cand_m >= thr_w);
  assign dec    = hist[0] ? dec_p : dec_m;
  assign eq     = hist[0] ? cand_p : cand_m;
endmodule

// File: rtl/spec_dfe.sv
module spec_dfe
  import dfe_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8,
  parameter int NTAPS    = 4,
  parameter int ACC_W    = acc_width(SAMPLE_W, COEF_W, NTAPS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic signed [SAMPLE_W-1:0]    in_sample,
  input  logic signed [SAMPLE_W-1:0]    slice_ref,
  input  logic                          coef_we,
  input  logic [$clog2(NTAPS)-1:0]      coef_idx,
  input  logic signed [COEF_W-1:0]      coef_val,
  output logic                          out_valid,
  output logic                          out_bit,
  output logic signed [ACC_W-1:0]       out_eq
);
  logic signed [COEF_W-1:0] coef [NTAPS];
  logic [NTAPS-1:0]         hist;
  logic                     accept, dec_c;
  logic signed [ACC_W-1:0]  eq_c;

  assign in_ready = ~rst;
  assign accept   = in_valid & in_ready;

  dfe_coef_bank #(.COEF_W(COEF_W), .NTAPS(NTAPS)) u_coef (
    .clk(clk), .rst(rst), .wr_en(coef_we), .wr_idx(coef_idx),
    .wr_val(coef_val), .coef_o(coef)
  );

  dfe_hist #(.NTAPS(NTAPS)) u_hist (
    .clk(clk), .rst(rst), .push(accept), .dec(dec_c), .hist_o(hist)
  );

  dfe_spec_slicer #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .NTAPS(NTAPS),
                    .ACC_W(ACC_W)) u_slice (
    .x(in_sample), .thr(slice_ref), .coef(coef), .hist(hist),
    .dec(dec_c), .eq(eq_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_eq    <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_bit <= dec_c;
        out_eq  <= eq_c;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid); // R6
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !out_valid); // R6
  AST_EQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(out_eq) && $stable(out_bit))); // R6
  AST_BIT_VS_REF: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_bit == (out_eq >= ACC_W'($past(slice_ref))))); // R5
  AST_BIT_IN_CHAIN: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_bit == hist[0])); // R3
  AST_READY_OUT_OF_RESET: assert property (@(posedge clk)
    rst |-> !in_ready); // R7
endmodule

// File: tb/sim_spec_dfe.sv
module sim_spec_dfe;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [7:0] in_sample = '0;
  logic signed [7:0] slice_ref = '0;
  logic coef_we = 1'b0;
  logic [1:0] coef_idx = '0;
  logic signed [7:0] coef_val = '0;
  logic out_valid, out_bit;
  logic signed [11:0] out_eq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  int mc [4];
  bit mh [4];
  int last_eq = 0;
  bit last_bit = 0;

  always #2 clk = ~clk;

  spec_dfe u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .slice_ref(slice_ref), .coef_we(coef_we),
    .coef_idx(coef_idx), .coef_val(coef_val), .out_valid(out_valid),
    .out_bit(out_bit), .out_eq(out_eq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: optional sample, optional weight write
  task automatic cyc(input bit v, input int x, input bit we, input int widx,
                     input int wval, input int thr, input string req);
    int e;
    bit eb;
    in_valid  = v;
    in_sample = x[7:0];
    slice_ref = thr[7:0];
    coef_we   = we;
    coef_idx  = widx[1:0];
    coef_val  = wval[7:0];
    e = x;
    for (int k = 0; k < 4; k++) e = e - mc[k] * (mh[k] ? 1 : -1);
    eb = (e >= thr);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    coef_we  = 1'b0;
    if (we) mc[widx] = wval;
    if (v) begin
      for (int k = 3; k > 0; k--) mh[k] = mh[k-1];
      mh[0] = eb;
      chk(out_valid == 1'b1, "R6", int'(out_valid), 1);
      chk(int'(out_eq) == e, req, int'(out_eq), e);
      chk(out_bit == eb, "R5", int'(out_bit), int'(eb));
      last_eq = e;
      last_bit = eb;
    end else begin
      chk(out_valid == 1'b0, "R6", int'(out_valid), 0);
      chk(int'(out_eq) == last_eq, "R6", int'(out_eq), last_eq);
      chk(out_bit == last_bit, "R6", int'(out_bit), int'(last_bit));
    end
  endtask

  task automatic set_coefs(input int a, input int b, input int c, input int d);
    cyc(0, 0, 1, 0, a, 0, "R2");
    cyc(0, 0, 1, 1, b, 0, "R2");
    cyc(0, 0, 1, 2, c, 0, "R2");
    cyc(0, 0, 1, 3, d, 0, "R2");
  endtask

  task automatic sweep(input int off, input int thr, input string req);
    for (int i = 0; i < 256; i++) begin
      int x;
      x = ((i * 37 + off) % 256) - 128;
      cyc(1, x, 0, 0, 0, thr, req);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000 && !done) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 200000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin mc[k] = 0; mh[k] = 1; end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state, R7 ready low in reset
    chk(in_ready == 1'b0, "R7", int'(in_ready), 0);
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(out_bit == 1'b0, "R1", int'(out_bit), 0);
    chk(int'(out_eq) == 0, "R1", int'(out_eq), 0);
    rst = 1'b0;
    #1;
    chk(in_ready == 1'b1, "R7", int'(in_ready), 1);

    // R1: zero weights after reset, so output equals input
    sweep(5, 0, "R1");
    // R1: chain reset to all +1, checked via a fresh reset then weights
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin mc[k] = 0; mh[k] = 1; end
    last_eq = 0; last_bit = 0;
    set_coefs(10, 20, 30, 40);
    cyc(1, 0, 0, 0, 0, 0, "R1");   // expect 0-100 = -100

    // R4 extremes, R3 chain evolution
    set_coefs(-128, -128, -128, -128);
    sweep(11, 0, "R4");
    set_coefs(127, 127, 127, 127);
    sweep(77, -5, "R4");
    set_coefs(20, -7, 3, -1);
    sweep(3, 17, "R4");
    sweep(200, -128, "R5");
    sweep(91, 127, "R5");

    // R3/R6: idle cycles leave chain and outputs unchanged
    cyc(1, 33, 0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 0, "R6");
    cyc(1, -40, 0, 0, 0, 0, "R3");
    cyc(1, 12, 0, 0, 0, 0, "R3");

    // R2: write and sample on the same edge use the old weight
    cyc(1, 50, 1, 0, 90, 0, "R2");
    cyc(1, 50, 0, 0, 0, 0, "R2");
    cyc(1, -20, 1, 3, -60, 3, "R2");
    cyc(1, -20, 0, 0, 0, 3, "R2");

    // R5 exact tie with zero weights
    set_coefs(0, 0, 0, 0);
    cyc(1, 5, 0, 0, 0, 5, "R5");
    cyc(1, 4, 0, 0, 0, 5, "R5");
    cyc(1, -128, 0, 0, 0, -128, "R5");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule